// File: doc/BRIEF.md
# Ground-Clamped Sinusoidal Three-Phase PWM Modulator

This block produces the three half-bridge drive enables for a brushless motor. It takes an electrical-angle index that advances with rotor position and a peak duty command, and compares them against an external free-running carrier count. For each phase it looks up a sinusoid, with the phases spaced a third of a cycle apart. It subtracts the smallest of the three instantaneous values, so that one phase always sits at 0% duty. It then scales the remaining span so that the largest value reached over an electrical cycle equals the duty command. The result is discontinuous modulation. The averaged phase-to-phase voltages follow a sinusoid. Each phase-to-ground average is a sinusoid with third-order harmonic content added.

The scaled duties and the sector indicator are taken into registers only when the carrier count is zero. A change of angle or command in the middle of a PWM period therefore never cuts that period short or stretches it. The sector output is one-hot and names the phase that is currently held at ground. Dead time, commutation timing and the choice of speed source belong to the surrounding logic.

Top module: `gcm_modulator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hs_en` is 000, `ls_en` is 111 and `sector` is 001.
- R2: The sample for angle a (0..255) is S(a). Let u = 2·(a mod 64)+1 when a[6]=0, or 2·(63−(a mod 64))+1 when a[6]=1. Let p = u·(256−u). The magnitude is floor(255·4p/(81920−p)), and it is negated when a[7]=1. Phase A uses S(a), phase B uses S((a−85) mod 256) and phase C uses S((a−171) mod 256).
- R3: The duty of phase k is floor((S_k − min(S_A,S_B,S_C))·C / SPAN). SPAN is the largest value of max−min of the three samples over all 256 angles.
- R4: The effective command C is duty_cmd when duty_cmd ≤ 256, and 256 otherwise.
- R5: The count used for comparison is the carrier value sampled at the previous clock edge. `hs_en[k]` is 1 exactly when that count is less than the duty of phase k. `ls_en[k]` is the complement of `hs_en[k]`. Within a period, a rising count never makes an enable go from 0 to 1.
- R6: New duties and a new sector are loaded only at a clock edge where `carrier` is 0. Changes to `angle` or `duty_cmd` at any other time have no effect on the outputs until that load.
- R7: `sector` is one-hot, with bit0 for phase A, bit1 for B and bit2 for C. It marks the phase with the minimum sample; on a tie the lowest-indexed phase wins. The marked phase never has its high side enabled.
- R8: A duty command of 0 keeps every high side off and every low side on for the whole period that follows the load.
- R9: Over the 256 angles, the largest duty equals C. At C=256 some phase is high for the whole period, giving the full supply. At C=128 the peak is half the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| angle | input | 8 | Electrical-angle index, 256 steps per electrical cycle |
| duty_cmd | input | 9 | Peak duty command, 256 = 100%, larger values saturate |
| carrier | input | 8 | Free-running PWM carrier count |
| hs_en | output | 3 | High-side enable per phase (bit0 = A) |
| ls_en | output | 3 | Low-side enable per phase |
| sector | output | 3 | One-hot phase currently clamped to ground |

## Verification
Angle and command are taken in at the first clock edge where the carrier is zero. From the count sampled at that same edge and at every later edge, the enables are decided by plain comparison. Each output is therefore due one edge after the carrier value that produced it. The bench drives each carrier value at a falling edge and checks the outputs at the next falling edge, against that value and the duties it last computed at a zero count. To probe each phase's threshold directly, the bench places the carrier at duty−1 and at duty, rather than running whole periods. It also changes the inputs at non-zero counts to show that the old duties persist until the next zero.

// File: rtl/gcm_pkg.sv
`timescale 1ns/1ps
package gcm_pkg;

   // magnitude of the quarter-wave entry q, sampled at half-step offsets
   function automatic int quarter_mag(input int q, input int aw, input int amp);
      int half;
      int u;
      int p;
      half = 2 ** aw;
      u    = 2 * q + 1;
      p    = u * (half - u);
      return (amp * 4 * p) / ((5 * half * half) / 4 - p);
   endfunction

   // signed sample for a full-range angle
   function automatic int full_sample(input int ang, input int aw, input int amp);
      int qtr;
      int q;
      int m;
      qtr = 2 ** (aw - 2);
      q   = ang % qtr;
      if (((ang / qtr) % 2) == 1) q = qtr - 1 - q;
      m = quarter_mag(q, aw, amp);
      return ((ang / (2 * qtr)) == 1) ? -m : m;
   endfunction

   // lag of phase k in angle steps, rounded third of a cycle
   function automatic int phase_off(input int k, input int aw);
      return (2 * k * (2 ** aw) + 3) / 6;
   endfunction

   // largest max-minus-min span over one electrical cycle
   function automatic int peak_span(input int aw, input int amp);
      int steps;
      int best;
      int s [3];
      int hi;
      int lo;
      steps = 2 ** aw;
      best  = 0;
      for (int a = 0; a < steps; a++) begin
         for (int k = 0; k < 3; k++)
            s[k] = full_sample((a - phase_off(k, aw) + steps) % steps, aw, amp);
         hi = s[0];
         lo = s[0];
         for (int k = 1; k < 3; k++) begin
            if (s[k] > hi) hi = s[k];
            if (s[k] < lo) lo = s[k];
         end
         if (hi - lo > best) best = hi - lo;
      end
      return best;
   endfunction

endpackage

// File: rtl/gcm_sine_lut.sv
`timescale 1ns/1ps
module gcm_sine_lut #(
   parameter int ANGLE_W = 8,
   parameter int AMP     = 255,
   parameter int MAG_W   = 8
) (
   input  logic [ANGLE_W-1:0]   angle,
   output logic signed [MAG_W:0] sample
);
   localparam int QTR = 2 ** (ANGLE_W - 2);

   logic [MAG_W-1:0] tbl [QTR];

   for (genvar g = 0; g < QTR; g++) begin : g_ent
      localparam int VAL = gcm_pkg::quarter_mag(g, ANGLE_W, AMP);
      assign tbl[g] = MAG_W'(VAL);
   end

   logic [ANGLE_W-3:0] q;
   logic [ANGLE_W-3:0] idx;
   logic signed [MAG_W:0] mag;

   always_comb begin
      q      = angle[ANGLE_W-3:0];
      idx    = angle[ANGLE_W-2] ? ~q : q;
      mag    = $signed({1'b0, tbl[idx]});
      sample = angle[ANGLE_W-1] ? -mag : mag;
   end
endmodule

// File: rtl/gcm_clamp_scale.sv
`timescale 1ns/1ps
module gcm_clamp_scale #(
   parameter int MAG_W = 8,
   parameter int CMD_W = 9,
   parameter int SPAN  = 441
) (
   input  logic signed [MAG_W:0] smp [3],
   input  logic [CMD_W-1:0]      cmd,
   output logic [CMD_W-1:0]      duty [3],
   output logic [2:0]            sector
);
   localparam int FS     = 2 ** (CMD_W - 1);
   localparam int DIFF_W = MAG_W + 2;
   localparam int PROD_W = DIFF_W + CMD_W;

   logic [CMD_W-1:0]         csat;
   logic signed [DIFF_W-1:0] w [3];
   logic signed [DIFF_W-1:0] wmin;
   logic [DIFF_W-1:0]        diff [3];
   logic [PROD_W-1:0]        prod [3];
   logic [PROD_W-1:0]        quo [3];

   always_comb begin
      csat = (cmd > CMD_W'(FS)) ? CMD_W'(FS) : cmd;
      for (int k = 0; k < 3; k++) w[k] = DIFF_W'(smp[k]);
      if (w[0] <= w[1] && w[0] <= w[2]) begin
         sector = 3'b001;
         wmin   = w[0];
      end else if (w[1] <= w[2]) begin
         sector = 3'b010;
         wmin   = w[1];
      end else begin
         sector = 3'b100;
         wmin   = w[2];
      end
      for (int k = 0; k < 3; k++) begin
         diff[k] = $unsigned(w[k] - wmin);
         prod[k] = PROD_W'(diff[k]) * PROD_W'(csat);
         quo[k]  = prod[k] / PROD_W'(SPAN);
         duty[k] = CMD_W'(quo[k]);
      end
   end
endmodule

// File: rtl/gcm_modulator.sv
`timescale 1ns/1ps
module gcm_modulator #(
   parameter int ANGLE_W = 8,
   parameter int CAR_W   = 8,
   parameter int AMP     = 255
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ANGLE_W-1:0] angle,
   input  logic [CAR_W:0]     duty_cmd,
   input  logic [CAR_W-1:0]   carrier,
   output logic [2:0]         hs_en,
   output logic [2:0]         ls_en,
   output logic [2:0]         sector
);
   localparam int CMD_W = CAR_W + 1;
   localparam int MAG_W = $clog2(AMP + 1);
   localparam int SPAN  = gcm_pkg::peak_span(ANGLE_W, AMP);

   if (ANGLE_W < 4 || ANGLE_W > 10) begin : g_bad_angle
      $error("gcm_modulator: ANGLE_W must lie in 4..10");
   end
   if (CAR_W < 2 || CAR_W > 16) begin : g_bad_car
      $error("gcm_modulator: CAR_W must lie in 2..16");
   end
   if (AMP < 3 || AMP > 1023) begin : g_bad_amp
      $error("gcm_modulator: AMP must lie in 3..1023");
   end
   if (SPAN <= 0) begin : g_bad_span
      $error("gcm_modulator: derived span is not positive");
   end

   logic signed [MAG_W:0] smp [3];
   logic [CMD_W-1:0]      duty_n [3];
   logic [2:0]            sector_n;

   for (genvar k = 0; k < 3; k++) begin : g_phase_lut
      localparam int OFF = gcm_pkg::phase_off(k, ANGLE_W);
      logic [ANGLE_W-1:0] ang_k;
      assign ang_k = angle - ANGLE_W'(OFF);
      gcm_sine_lut #(
         .ANGLE_W(ANGLE_W),
         .AMP    (AMP),
         .MAG_W  (MAG_W)
      ) u_lut (
         .angle (ang_k),
         .sample(smp[k])
      );
   end

   gcm_clamp_scale #(
      .MAG_W(MAG_W),
      .CMD_W(CMD_W),
      .SPAN (SPAN)
   ) u_scale (
      .smp   (smp),
      .cmd   (duty_cmd),
      .duty  (duty_n),
      .sector(sector_n)
   );

   logic [CAR_W-1:0] cnt_q;
   logic [CMD_W-1:0] duty_q [3];
   logic [2:0]       sector_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         sector_q <= 3'b001;
         for (int k = 0; k < 3; k++) duty_q[k] <= '0;
      end else begin
         cnt_q <= carrier;
         if (carrier == '0) begin
            sector_q <= sector_n;
            for (int k = 0; k < 3; k++) duty_q[k] <= duty_n[k];
         end
      end
   end

   for (genvar k = 0; k < 3; k++) begin : g_cmp
      assign hs_en[k] = ({1'b0, cnt_q} < duty_q[k]);
      assign ls_en[k] = ~hs_en[k];
   end

   assign sector = sector_q;
endmodule

// File: rtl/gcm_modulator_chk.sv
`timescale 1ns/1ps
module gcm_modulator_chk #(
   parameter int CAR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CAR_W:0]   duty_cmd,
   input logic [CAR_W-1:0] carrier,
   input logic [2:0]       hs_en,
   input logic [2:0]       ls_en,
   input logic [2:0]       sector
);
   p_sector_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sector) == 1);

   p_clamped_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en & sector) == 3'b000);

   p_sector_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (carrier != '0) |=> $stable(sector));

   p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (carrier != '0 && carrier > $past(carrier)) |=> ((hs_en & ~$past(hs_en)) == 3'b000));

   p_zero_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (carrier == '0 && duty_cmd == '0) |=> (hs_en == 3'b000 && ls_en == 3'b111));
endmodule

bind gcm_modulator gcm_modulator_chk #(.CAR_W(CAR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .duty_cmd(duty_cmd),
   .carrier (carrier),
   .hs_en   (hs_en),
   .ls_en   (ls_en),
   .sector  (sector)
);

// File: tb/gcm_modulator_test.sv
`timescale 1ns/1ps
module gcm_modulator_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] angle = 8'd0;
   logic [8:0] duty_cmd = 9'd0;
   logic [7:0] carrier = 8'd0;
   logic [2:0] hs_en;
   logic [2:0] ls_en;
   logic [2:0] sector;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int span;
   int exp_d [3];
   int exp_sec;
   bit peak_seen;

   always #4 clk = ~clk;

   gcm_modulator uut (
      .clk(clk), .rst_n(rst_n), .angle(angle), .duty_cmd(duty_cmd),
      .carrier(carrier), .hs_en(hs_en), .ls_en(ls_en), .sector(sector)
   );

   function automatic int smp(input int a);
      int q;
      int u;
      int p;
      int m;
      q = a % 64;
      if (((a / 64) % 2) == 1) q = 63 - q;
      u = 2 * q + 1;
      p = u * (256 - u);
      m = (255 * 4 * p) / (81920 - p);
      return (a >= 128) ? -m : m;
   endfunction

   function automatic int ph(input int a, input int k);
      int off;
      off = (k == 0) ? 0 : (k == 1) ? 85 : 171;
      return smp((a - off + 256) % 256);
   endfunction

   task automatic load_exp();
      int s [3];
      int mn;
      int c;
      c = (int'(duty_cmd) > 256) ? 256 : int'(duty_cmd);
      for (int k = 0; k < 3; k++) s[k] = ph(int'(angle), k);
      if (s[0] <= s[1] && s[0] <= s[2]) begin mn = s[0]; exp_sec = 1; end
      else if (s[1] <= s[2]) begin mn = s[1]; exp_sec = 2; end
      else begin mn = s[2]; exp_sec = 4; end
      for (int k = 0; k < 3; k++) exp_d[k] = ((s[k] - mn) * c) / span;
   endtask

   task automatic check_outs(input int c, input string tag);
      logic [2:0] eh;
      for (int k = 0; k < 3; k++) eh[k] = (c < exp_d[k]);
      checks++;
      if (hs_en !== eh) begin
         errors++;
         $display("FAIL %s hs_en ang=%0d cmd=%0d cnt=%0d actual=%b expected=%b",
                  tag, angle, duty_cmd, c, hs_en, eh);
      end
      checks++;
      if (ls_en !== ~eh) begin
         errors++;
         $display("FAIL R5 ls_en cnt=%0d actual=%b expected=%b", c, ls_en, ~eh);
      end
      checks++;
      if (sector !== 3'(exp_sec)) begin
         errors++;
         $display("FAIL R7 sector ang=%0d actual=%b expected=%b", angle, sector, 3'(exp_sec));
      end
   endtask

   task automatic step(input int c, input string tag);
      carrier = 8'(c);
      if (c == 0) load_exp();
      @(negedge clk);
      check_outs(c, tag);
   endtask

   task automatic sweep(input int cmd, input string tag);
      int csat;
      int t;
      csat = (cmd > 256) ? 256 : cmd;
      peak_seen = 1'b0;
      duty_cmd = 9'(cmd);
      for (int a = 0; a < 256; a++) begin
         angle = 8'(a);
         step(0, tag);
         for (int j = 0; j < 4; j++) begin
            t = (j < 3) ? exp_d[j] : csat;
            if (t >= 1 && t <= 256) begin
               step(t - 1, tag);
               if (j == 3 && hs_en != 3'b000) peak_seen = 1'b1;
            end
            if (t >= 1 && t <= 255) step(t, tag);
         end
      end
      if (csat > 0) begin
         checks++;
         if (!peak_seen) begin
            errors++;
            $display("FAIL R9 cmd=%0d peak duty not reached actual=below expected=%0d", cmd, csat);
         end
      end
   endtask

   initial begin
      span = 0;
      for (int a = 0; a < 256; a++) begin
         int hi;
         int lo;
         hi = ph(a, 0);
         lo = hi;
         for (int k = 1; k < 3; k++) begin
            if (ph(a, k) > hi) hi = ph(a, k);
            if (ph(a, k) < lo) lo = ph(a, k);
         end
         if (hi - lo > span) span = hi - lo;
      end

      repeat (4) @(negedge clk);
      checks++;
      if (hs_en !== 3'b000 || ls_en !== 3'b111 || sector !== 3'b001) begin
         errors++;
         $display("FAIL R1 in reset actual=%b/%b/%b expected=000/111/001", hs_en, ls_en, sector);
      end
      rst_n = 1'b1;
      carrier = 8'd9;
      @(negedge clk);
      checks++;
      if (hs_en !== 3'b000 || ls_en !== 3'b111 || sector !== 3'b001) begin
         errors++;
         $display("FAIL R1 after reset actual=%b/%b/%b expected=000/111/001", hs_en, ls_en, sector);
      end

      sweep(256, "R2/R3 full");
      sweep(128, "R3 half");
      sweep(77,  "R3 odd");
      sweep(300, "R4 sat300");
      sweep(511, "R4 sat511");
      sweep(0,   "R8 zero");

      // R6: inputs changed mid-period keep the loaded duties
      angle = 8'd10;
      duty_cmd = 9'd256;
      step(0, "R6 load");
      angle = 8'd100;
      duty_cmd = 9'd50;
      for (int k = 0; k < 3; k++) begin
         if (exp_d[k] >= 1 && exp_d[k] <= 255) begin
            step(exp_d[k] - 1, "R6 hold");
            step(exp_d[k], "R6 hold");
         end
      end
      step(200, "R6 hold");
      step(0, "R6 reload");
      step(exp_d[0] > 0 ? exp_d[0] - 1 : 1, "R6 reload");

      // R5: ascending full period, then zero command period (R8)
      angle = 8'd37;
      duty_cmd = 9'd180;
      for (int c = 0; c < 256; c++) step(c, "R5 ramp");
      duty_cmd = 9'd0;
      for (int c = 0; c < 256; c += 17) step(c, "R8 period");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule